// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a free-running down-counting watchdog that asks for a system reset when software stops servicing it. Its time base is a single-cycle tick enable that stands for a slow, separate oscillator. The tick enable drives a prescaler with a selectable power-of-two divide, and each prescaled tick lowers a 12-bit counter by one. When the counter reaches zero the block raises a one-cycle reset request.

All control goes through a 32-bit register bus with address, write enable, write data and read data. Software writes 16-bit command words to a key register to start the watchdog, refresh the counter, and lock or unlock the three configuration registers: divide code, reload value and window value. A new configuration value takes effect only after a short settling delay counted in ticks. A status register shows which values are still settling. A window value below the maximum makes a refresh that arrives too early a fault, and that fault also requests a reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, the reset request is low, the configuration is locked, status reads 0, divide code (offset 0x04) reads 0, reload (offset 0x08) reads 0xFFF and window (offset 0x0C) reads 0xFFF.
- R2: Writing 0xCCCC to the key register (offset 0x00, bits 15:0) while stopped loads the counter from the reload value and starts it. The counter drops by one per prescaled tick. The reset request is high for exactly one cycle, right after the tick-enable pulse that takes the counter from 1 to 0.
- R3: Once started, the watchdog keeps running until reset, whatever key words are written.
- R4: Writing 0xAAAA to the key register reloads the counter from the reload value, which restarts the full timeout.
- R5: Writing 0x5555 to the key register unlocks the configuration registers and writing 0x0000 locks them again. A configuration write while locked changes neither the register nor the status.
- R6: The key register always reads as zero.
- R7: Divide codes 0 to 5 give dividers 4, 8, 16, 32, 64 and 128. Codes 6 and 7 both give 256.
- R8: Status (offset 0x10) bit 0 flags a pending divide code, bit 1 a pending reload value and bit 2 a pending window value. A flag sets on an accepted write and clears on the second tick-enable pulse after it (SYNC_TICKS = 2). The new value is in force from that point.
- R9: If the window value is below 0xFFF and the watchdog is running, a refresh key that arrives while the counter is above the window value raises a one-cycle reset request and leaves the counter unchanged. A counter equal to the window value is accepted.
- R10: With the window value at 0xFFF, a refresh is accepted at any counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle time-base tick from the slow-clock model |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with its default parameters: a 12-bit counter and a 2-tick settling delay. Small reload values keep every timeout within a few hundred cycles, so each divide code, including both codes that give 256, can be timed against its exact tick count. The same small reloads let the bench set the counter exactly at, above and below a window of 10, which covers the early-refresh fault and its equality boundary.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [15:0] KEY_START  = 16'hCCCC;
  localparam logic [15:0] KEY_REFILL = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN   = 16'h5555;
  localparam logic [15:0] KEY_CLOSE  = 16'h0000;

  localparam int DIV_CODE_W = 3;
  localparam int DIV_CNT_W  = 9;

  typedef enum logic [2:0] {
    REG_KEY    = 3'd0,
    REG_DIV    = 3'd1,
    REG_RELOAD = 3'd2,
    REG_WINDOW = 3'd3,
    REG_STATUS = 3'd4
  } reg_idx_e;

  // Divider ratio for a divide code: 4 << code, saturating at 256.
  function automatic logic [DIV_CNT_W-1:0] divider_of(input logic [DIV_CODE_W-1:0] code);
    if (code >= 3'd6) return 9'd256;
    return 9'd4 << code;
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  tick_en,
  input  logic [DIV_CODE_W-1:0] code,
  output logic                  ptick
);
  logic [DIV_CNT_W-1:0] pcnt;
  logic [DIV_CNT_W-1:0] div_last;
  logic                 wrap;

  assign div_last = divider_of(code) - 9'd1;
  assign wrap     = (pcnt >= div_last);
  assign ptick    = run && tick_en && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt <= '0;
    end else if (tick_en) begin
      pcnt <= wrap ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_cfg_slot.sv
module wdg_cfg_slot #(
  parameter int         W          = 12,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter int         SYNC_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         tick_en,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         pending
);
  localparam int SW = $clog2(SYNC_TICKS + 1);
  localparam logic [SW-1:0] SLAST = SW'(SYNC_TICKS - 1);

  logic [SW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= RST_VAL;
      active  <= RST_VAL;
      pending <= 1'b0;
      scnt    <= '0;
    end else if (wr) begin
      shadow  <= wval;
      pending <= 1'b1;
      scnt    <= '0;
    end else if (pending && tick_en) begin
      if (scnt == SLAST) begin
        pending <= 1'b0;
        active  <= shadow;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_start,
  input  logic             key_reload,
  input  logic             ptick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] window_val,
  output logic             started,
  output logic [CNT_W-1:0] cnt,
  output logic             timeout,
  output logic             win_fault,
  output logic             rst_req
);
  logic window_on;
  logic load_now;

  assign window_on = (window_val != '1);
  assign win_fault = key_reload && started && window_on && (cnt > window_val);
  assign load_now  = (key_start && !started) || (key_reload && !win_fault);
  assign timeout   = ptick && !load_now && !win_fault && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= timeout || win_fault;
      if (key_start) started <= 1'b1;
      if (load_now) begin
        cnt <= reload_val;
      end else if (ptick && !win_fault && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int SYNC_TICKS = 2,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam int NCFG  = 3;
  localparam int CFG_W = CNT_W;

  logic [ADDR_W-3:0] idx;
  logic              key_wr, key_start, key_reload;
  logic              unlocked;
  logic [NCFG-1:0]   cfg_wr, cfg_try, pend;
  logic [NCFG*CFG_W-1:0] shadow_flat, active_flat;
  logic              ptick, started, timeout, win_fault;
  logic [CNT_W-1:0]  cnt;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata};
  assign idx        = bus_addr[ADDR_W-1:2];
  assign key_wr     = bus_we && (idx == (ADDR_W-2)'(REG_KEY));
  assign key_start  = key_wr && (bus_wdata[15:0] == KEY_START);
  assign key_reload = key_wr && (bus_wdata[15:0] == KEY_REFILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (key_wr && bus_wdata[15:0] == KEY_OPEN) begin
      unlocked <= 1'b1;
    end else if (key_wr && bus_wdata[15:0] == KEY_CLOSE) begin
      unlocked <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam int FW = (g == 0) ? DIV_CODE_W : CNT_W;
    localparam logic [CFG_W-1:0] FMASK = CFG_W'((64'd1 << FW) - 1);
    localparam logic [CFG_W-1:0] RSTV  = (g == 0) ? '0 : FMASK;
    assign cfg_try[g] = bus_we && (idx == (ADDR_W-2)'(g + 1));
    assign cfg_wr[g]  = cfg_try[g] && unlocked;
    wdg_cfg_slot #(.W(CFG_W), .RST_VAL(RSTV), .SYNC_TICKS(SYNC_TICKS)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr[g]),
      .wval    (bus_wdata[CFG_W-1:0] & FMASK),
      .tick_en (tick_en),
      .shadow  (shadow_flat[g*CFG_W +: CFG_W]),
      .active  (active_flat[g*CFG_W +: CFG_W]),
      .pending (pend[g])
    );
  end

  wdg_prescaler u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (started),
    .tick_en (tick_en),
    .code    (active_flat[DIV_CODE_W-1:0]),
    .ptick   (ptick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_start  (key_start),
    .key_reload (key_reload),
    .ptick      (ptick),
    .reload_val (active_flat[CFG_W +: CFG_W]),
    .window_val (active_flat[2*CFG_W +: CFG_W]),
    .started    (started),
    .cnt        (cnt),
    .timeout    (timeout),
    .win_fault  (win_fault),
    .rst_req    (rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (idx)
      (ADDR_W-2)'(REG_DIV):    bus_rdata = 32'(shadow_flat[0 +: CFG_W]);
      (ADDR_W-2)'(REG_RELOAD): bus_rdata = 32'(shadow_flat[CFG_W +: CFG_W]);
      (ADDR_W-2)'(REG_WINDOW): bus_rdata = 32'(shadow_flat[2*CFG_W +: CFG_W]);
      (ADDR_W-2)'(REG_STATUS): bus_rdata = 32'(pend);
      default:                 bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              rst_req,
  input logic              started,
  input logic              key_reload,
  input logic              win_fault,
  input logic              timeout,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload_act,
  input logic [CNT_W-1:0]  window_act,
  input logic              unlocked,
  input logic [2:0]        cfg_try,
  input logic [3*CNT_W-1:0] shadow_flat
);
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> started); // R3
  AST_REFRESH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_reload && !win_fault) |=> cnt == $past(reload_act)); // R4
  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(timeout || win_fault)); // R2
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:2] == '0) |-> bus_rdata == '0); // R6
  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && |cfg_try) |=> $stable(shadow_flat)); // R5
  AST_OPEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (key_reload && started && window_act == '1) |=> !rst_req); // R10
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .rst_req     (rst_req),
  .started     (started),
  .key_reload  (key_reload),
  .win_fault   (win_fault),
  .timeout     (timeout),
  .cnt         (cnt),
  .reload_act  (active_flat[CNT_W +: CNT_W]),
  .window_act  (active_flat[2*CNT_W +: CNT_W]),
  .unlocked    (unlocked),
  .cfg_try     (cfg_try),
  .shadow_flat (shadow_flat)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_KEY = 5'h00, A_DIV = 5'h04, A_RL = 5'h08,
                         A_WIN = 5'h0C, A_ST = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick_en = t; bus_we = 1'b0;
    @(posedge clk); #1;
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_en = 1'b0;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0; #1; d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(0); cyc(0); rst_n = 1'b1; cyc(0);
  endtask

  task automatic configure(input int code, input int rl, input int win);
    wr(A_KEY, 32'h5555); wr(A_DIV, code); wr(A_RL, rl); wr(A_WIN, win);
    wr(A_KEY, 32'h0000); cyc(1); cyc(1);
  endtask

  // n ticks; reports whether any request was seen
  task automatic ticks(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (rst_req) seen = 1'b1;
    end
  endtask

  // expect a request exactly on tick n, low before and after
  task automatic expect_timeout(input string req, input int n);
    bit seen;
    ticks(n - 1, seen);
    check({req, " early request"}, seen, 0);
    cyc(1);
    check({req, " request at limit"}, rst_req, 1);
    cyc(0);
    check({req, " request one cycle"}, rst_req, 0);
  endtask

  task automatic t_reset_state(); // R1, R6
    logic [31:0] d;
    do_reset();
    check("R1 rst_req", rst_req, 0);
    rd(A_DIV, d); check("R1 div", d, 0);
    rd(A_RL, d);  check("R1 reload", d, 32'hFFF);
    rd(A_WIN, d); check("R1 window", d, 32'hFFF);
    rd(A_ST, d);  check("R1 status", d, 0);
    begin bit seen; ticks(40, seen); check("R1 stopped", seen, 0); end
    wr(A_RL, 32'h5); rd(A_RL, d); check("R1 locked", d, 32'hFFF);
  endtask

  task automatic t_start_timeout(); // R2, R6
    logic [31:0] d;
    do_reset(); configure(0, 5, 32'hFFF);
    wr(A_KEY, 32'hCCCC);
    rd(A_KEY, d); check("R6 key reads zero", d, 0);
    expect_timeout("R2", 20);
  endtask

  task automatic t_no_stop(); // R3
    do_reset(); configure(0, 3, 32'hFFF);
    wr(A_KEY, 32'hCCCC);
    wr(A_KEY, 32'h0000); wr(A_KEY, 32'h1234); wr(A_KEY, 32'hCCCC);
    expect_timeout("R3", 12);
  endtask

  task automatic t_refresh(); // R4
    bit seen;
    do_reset(); configure(0, 5, 32'hFFF);
    wr(A_KEY, 32'hCCCC);
    ticks(16, seen); check("R4 before refresh", seen, 0);
    wr(A_KEY, 32'hAAAA);
    check("R4 refresh no request", rst_req, 0);
    expect_timeout("R4", 20);
  endtask

  task automatic t_lock(); // R5
    logic [31:0] d;
    do_reset();
    wr(A_WIN, 32'h7); rd(A_WIN, d); check("R5 locked write", d, 32'hFFF);
    rd(A_ST, d); check("R5 locked status", d, 0);
    wr(A_KEY, 32'h5555); wr(A_WIN, 32'h7);
    rd(A_WIN, d); check("R5 unlocked write", d, 32'h7);
    wr(A_KEY, 32'h0000); wr(A_WIN, 32'h9);
    rd(A_WIN, d); check("R5 relocked write", d, 32'h7);
  endtask

  task automatic t_dividers(); // R7
    for (int c = 0; c < 8; c++) begin
      int dv;
      dv = (c >= 6) ? 256 : (4 << c);
      do_reset(); configure(c, 1, 32'hFFF);
      wr(A_KEY, 32'hCCCC);
      expect_timeout($sformatf("R7 code %0d", c), dv);
    end
  endtask

  task automatic t_status(); // R8
    logic [31:0] d;
    do_reset(); wr(A_KEY, 32'h5555);
    wr(A_RL, 32'h2);
    rd(A_ST, d); check("R8 reload pending", d, 32'h2);
    wr(A_DIV, 32'h1); wr(A_WIN, 32'hFFF);
    rd(A_ST, d); check("R8 all pending", d, 32'h7);
    cyc(1); rd(A_ST, d); check("R8 after one tick", d, 32'h7);
    cyc(1); rd(A_ST, d); check("R8 after two ticks", d, 32'h0);
    wr(A_KEY, 32'hCCCC);
    expect_timeout("R8 new values", 16);
  endtask

  task automatic t_window(); // R9
    bit seen;
    do_reset(); configure(0, 20, 10);
    wr(A_KEY, 32'hCCCC);
    wr(A_KEY, 32'hAAAA);
    check("R9 early refresh request", rst_req, 1);
    cyc(0); check("R9 request one cycle", rst_req, 0);
    ticks(40, seen); check("R9 counter kept", seen, 0);
    wr(A_KEY, 32'hAAAA);
    check("R9 refresh at window edge", rst_req, 0);
    expect_timeout("R9 refreshed", 80);
  endtask

  task automatic t_open_window(); // R10
    do_reset(); configure(0, 20, 32'hFFF);
    wr(A_KEY, 32'hCCCC); wr(A_KEY, 32'hAAAA);
    check("R10 open window", rst_req, 0);
    cyc(0); check("R10 open window next", rst_req, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_start_timeout();
    t_no_stop();
    t_refresh();
    t_lock();
    t_dividers();
    t_status();
    t_window();
    t_open_window();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule